// File: doc/BRIEF.md
# Bidirectional Inactivity Watchdog

This block observes a request/response interface during a test run and flags a stall. Every clock it receives a one-cycle pulse for each request sent and each response received, a run-active enable and a programmable idle limit. A cycle is idle only when both directions are silent. The block counts consecutive idle cycles, and any traffic in either direction clears the count.

The count runs only while the run-active enable is high. That enable comes from the run-start control bit. When the count first exceeds the limit, a stall flag is set. The flag stays set through later traffic and clears only on reset or when the run stops. The count saturates and does not wrap. It is visible on an output so that a monitor can read how long the interface has been quiet.

The reset input is asynchronous and active low. Inside the block its release is synchronised to the clock through a short flop chain.

Top module: `inactivity_watchdog`

## Requirements
- R1: After reset, the idle count is 0 and the stall flag is 0.
- R2: While run_en is low, request and response pulses have no effect; the idle count stays 0 and the stall flag stays 0.
- R3: With run_en high and neither pulse present in a cycle, the idle count increases by one at the next clock edge.
- R4: A request pulse with run_en high sets the idle count to 0 at the next clock edge.
- R5: A response pulse with run_en high sets the idle count to 0 at the next clock edge; both pulses together also clear it.
- R6: The stall flag is set on the same edge at which the idle count becomes strictly greater than idle_limit. A count equal to idle_limit does not set it. With a limit of 0, the first idle cycle sets it.
- R7: Once set, the stall flag stays at 1 while run_en stays high, including through request and response pulses.
- R8: Dropping run_en clears both the idle count and the stall flag at the next clock edge.
- R9: The idle count saturates at 2^CNT_W-1 and does not wrap.
- R10: idle_limit is compared against the count on every cycle. If the limit is lowered below the running count, the flag is set on the next idle edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run active; counting is armed only while high |
| req_pulse | input | 1 | One-cycle pulse: a request was issued |
| rsp_pulse | input | 1 | One-cycle pulse: a response arrived |
| idle_limit | input | THR_W (32) | Idle-cycle threshold |
| idle_count | output | CNT_W (32) | Current consecutive idle-cycle count |
| stall_flag | output | 1 | Sticky stall indication |

## Verification
The hardest case to reach from the ports is saturation. A 32-bit count would need about four billion idle cycles before it clamps. The bench therefore drives a second instance that shares the same stimulus but has a 6-bit counter, so that instance clamps at 63 within a hundred idle cycles. Meanwhile the full-width instance keeps counting, and both are compared each cycle against a behavioural model. The bench also lowers the limit below a running count and uses a limit of zero to reach the edges of the strict-greater rule.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Classification of one clock cycle as seen by the idle counter.
  typedef enum logic [1:0] {
    CYC_OFF    = 2'd0,  // run not active: hold everything cleared
    CYC_BUSY   = 2'd1,  // traffic seen in at least one direction
    CYC_QUIET  = 2'd2   // run active and both directions silent
  } cyc_kind_e;

endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/wdg_cycle_classify.sv
module wdg_cycle_classify
  import wdg_pkg::*;
(
  input  logic      run_en,
  input  logic      req_pulse,
  input  logic      rsp_pulse,
  output cyc_kind_e kind
);

  always_comb begin
    if (!run_en) begin
      kind = CYC_OFF;
    end else if (req_pulse || rsp_pulse) begin
      kind = CYC_BUSY;
    end else begin
      kind = CYC_QUIET;
    end
  end

endmodule

// File: rtl/wdg_idle_counter.sv
module wdg_idle_counter
  import wdg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cyc_kind_e        kind,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic at_max;
  logic cnt_en;

  assign at_max = (cnt_q == CNT_MAX);

  // Register only loads when the value can change.
  always_comb begin
    cnt_nxt = cnt_q;
    cnt_en  = 1'b0;
    unique case (kind)
      CYC_OFF, CYC_BUSY: begin
        cnt_nxt = '0;
        cnt_en  = (cnt_q != '0);
      end
      CYC_QUIET: begin
        cnt_nxt = at_max ? cnt_q : cnt_q + 1'b1;
        cnt_en  = !at_max;
      end
      default: begin
        cnt_nxt = '0;
        cnt_en  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

endmodule

// File: rtl/wdg_stall_flag.sv
module wdg_stall_flag #(
  parameter int CNT_W = 32,
  parameter int THR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [THR_W-1:0] limit,
  output logic             flag_q
);

  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] cnt_ext;
  logic [CMP_W-1:0] lim_ext;
  logic             over;
  logic             flag_d;
  logic             flag_en;

  assign cnt_ext = CMP_W'(cnt_nxt);
  assign lim_ext = CMP_W'(limit);
  assign over    = (cnt_ext > lim_ext);

  always_comb begin
    flag_d  = run_en && (flag_q || over);
    flag_en = (flag_d != flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/inactivity_watchdog.sv
module inactivity_watchdog
  import wdg_pkg::*;
#(
  parameter int THR_W       = 32,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             req_pulse,
  input  logic             rsp_pulse,
  input  logic [THR_W-1:0] idle_limit,
  output logic [CNT_W-1:0] idle_count,
  output logic             stall_flag
);

  logic             rst_sync_n;
  cyc_kind_e        kind;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             flag_q;

  wdg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdg_cycle_classify u_classify (
    .run_en    (run_en),
    .req_pulse (req_pulse),
    .rsp_pulse (rsp_pulse),
    .kind      (kind)
  );

  wdg_idle_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .kind    (kind),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  wdg_stall_flag #(.CNT_W(CNT_W), .THR_W(THR_W)) u_flag (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run_en  (run_en),
    .cnt_nxt (cnt_nxt),
    .limit   (idle_limit),
    .flag_q  (flag_q)
  );

  assign idle_count = cnt_q;
  assign stall_flag = flag_q;

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int CNT_W = 32,
  parameter int THR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             req_pulse,
  input logic             rsp_pulse,
  input logic [THR_W-1:0] idle_limit,
  input logic [CNT_W-1:0] idle_count,
  input logic             stall_flag
);

  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R2, R8: a stopped run leaves everything cleared
  a_r2_cleared_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (idle_count == '0) && !stall_flag);

  // R4, R5: traffic clears the count
  a_r4_activity_clears: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && (req_pulse || rsp_pulse) |=> idle_count == '0);

  // R3: a quiet cycle below the ceiling advances the count by one
  a_r3_quiet_step: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && !req_pulse && !rsp_pulse && (idle_count != CNT_MAX)
    |=> idle_count == $past(idle_count) + 1'b1);

  // R9: the count holds at its ceiling
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && !req_pulse && !rsp_pulse && (idle_count == CNT_MAX)
    |=> idle_count == CNT_MAX);

  // R7: the flag stays set while the run continues
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && stall_flag |=> stall_flag);

  // R6: the flag only rises once the count exceeds the limit in force
  a_r6_rise_over_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_flag) |-> CMP_W'(idle_count) > CMP_W'($past(idle_limit)));

endmodule

bind inactivity_watchdog wdg_checker #(.CNT_W(CNT_W), .THR_W(THR_W)) u_wdg_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .run_en     (run_en),
  .req_pulse  (req_pulse),
  .rsp_pulse  (rsp_pulse),
  .idle_limit (idle_limit),
  .idle_count (idle_count),
  .stall_flag (stall_flag)
);

// File: tb/test_inactivity_watchdog.sv
`timescale 1ns/1ps
module test_inactivity_watchdog;

  localparam int NARROW_W = 6;

  logic        clk;
  logic        rst_n;
  logic        run_en;
  logic        req_pulse;
  logic        rsp_pulse;
  logic [31:0] idle_limit;
  logic [31:0] cnt_wide;
  logic        flag_wide;
  logic [NARROW_W-1:0] cnt_narrow;
  logic        flag_narrow;

  int n_cmp;
  int n_bad;
  int cyc;
  bit done;
  string cur_req;

  longint m_wide, m_narrow;
  bit     mf_wide, mf_narrow;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  inactivity_watchdog i_inactivity_watchdog (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .req_pulse(req_pulse),
    .rsp_pulse(rsp_pulse), .idle_limit(idle_limit),
    .idle_count(cnt_wide), .stall_flag(flag_wide));

  inactivity_watchdog #(.CNT_W(NARROW_W)) i_inactivity_watchdog_narrow (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .req_pulse(req_pulse),
    .rsp_pulse(rsp_pulse), .idle_limit(idle_limit),
    .idle_count(cnt_narrow), .stall_flag(flag_narrow));

  // Behavioural reference: one step per clock edge, written from the requirements.
  function automatic void model_step(ref longint c, ref bit f, input longint cmax);
    if (!run_en) begin
      c = 0; f = 0;
    end else if (req_pulse || rsp_pulse) begin
      c = 0;
    end else begin
      if (c < cmax) c = c + 1;
      if (c > longint'(idle_limit)) f = 1;
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wide = 0; m_narrow = 0; mf_wide = 0; mf_narrow = 0;
    end else begin
      model_step(m_wide, mf_wide, 64'hFFFF_FFFF);
      model_step(m_narrow, mf_narrow, (64'd1 << NARROW_W) - 1);
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, "wide count",   longint'(cnt_wide),   m_wide);
      check(cur_req, "wide flag",    longint'(flag_wide),  longint'(mf_wide));
      check(cur_req, "narrow count", longint'(cnt_narrow), m_narrow);
      check(cur_req, "narrow flag",  longint'(flag_narrow), longint'(mf_narrow));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic step(input bit r, input bit s);
    req_pulse = r;
    rsp_pulse = s;
    @(posedge clk);
    #2;
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0; done = 0;
    cur_req = "R1";
    rst_n = 1'b0; run_en = 1'b0; req_pulse = 1'b0; rsp_pulse = 1'b0;
    idle_limit = 32'd5;
    repeat (3) @(posedge clk);
    #2;
    check("R1", "reset count", longint'(cnt_wide), 0);
    check("R1", "reset flag", longint'(flag_wide), 0);
    rst_n = 1'b1;
    repeat (4) step(0, 0);

    // R2: pulses with the run stopped are ignored
    cur_req = "R2";
    step(1, 0); step(0, 1);
    repeat (10) step(0, 0);
    check("R2", "count off", longint'(cnt_wide), 0);
    check("R2", "flag off", longint'(flag_wide), 0);

    // R3: counting quiet cycles
    cur_req = "R3";
    run_en = 1'b1;
    repeat (3) step(0, 0);
    check("R3", "count after 3 quiet", longint'(cnt_wide), 3);

    // R4: request clears
    cur_req = "R4";
    step(1, 0);
    check("R4", "count after request", longint'(cnt_wide), 0);

    // R5: response clears, both together clear
    cur_req = "R5";
    repeat (2) step(0, 0);
    step(0, 1);
    check("R5", "count after response", longint'(cnt_wide), 0);
    repeat (4) step(0, 0);
    step(1, 1);
    check("R5", "count after both", longint'(cnt_wide), 0);

    // R6: equal does not trip, one more does
    cur_req = "R6";
    repeat (5) step(0, 0);
    check("R6", "count at limit", longint'(cnt_wide), 5);
    check("R6", "flag at limit", longint'(flag_wide), 0);
    step(0, 0);
    check("R6", "count over limit", longint'(cnt_wide), 6);
    check("R6", "flag over limit", longint'(flag_wide), 1);

    // R7: sticky through traffic
    cur_req = "R7";
    step(1, 0); step(0, 1); step(0, 0);
    check("R7", "flag after traffic", longint'(flag_wide), 1);
    check("R7", "count after traffic", longint'(cnt_wide), 1);

    // R8: stopping the run clears
    cur_req = "R8";
    run_en = 1'b0;
    step(0, 0);
    check("R8", "count after stop", longint'(cnt_wide), 0);
    check("R8", "flag after stop", longint'(flag_wide), 0);

    // R6: zero limit trips on the first quiet cycle
    cur_req = "R6";
    idle_limit = 32'd0;
    run_en = 1'b1;
    step(0, 0);
    check("R6", "flag with zero limit", longint'(flag_wide), 1);
    run_en = 1'b0;
    step(0, 0);

    // R9: narrow instance saturates, wide one keeps counting
    cur_req = "R9";
    idle_limit = 32'd1000;
    run_en = 1'b1;
    repeat (100) step(0, 0);
    check("R9", "narrow saturated", longint'(cnt_narrow), 63);
    check("R9", "wide count", longint'(cnt_wide), 100);
    check("R9", "wide flag below limit", longint'(flag_wide), 0);

    // R10: lowering the limit below the running count
    cur_req = "R10";
    idle_limit = 32'd50;
    step(0, 0);
    check("R10", "wide flag after lower", longint'(flag_wide), 1);
    check("R10", "narrow flag after lower", longint'(flag_narrow), 1);
    check("R10", "narrow still saturated", longint'(cnt_narrow), 63);

    cur_req = "R8";
    run_en = 1'b0;
    repeat (3) step(0, 0);
    finish_run();
  end

endmodule